// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a simple synchronous host port and a byte-wide asynchronous static RAM. The host raises `req` for one clock while the sequencer is idle, with a write flag, an address and write data. The sequencer then drives the memory's active-low select, write and output-enable strobes in a fixed order. All of them are registered outputs. It also runs the data bus toward the memory and pulses `done` when the access is finished. For reads, the byte that comes back is held on `rd_data`.

The memory's minimum timings are given in nanoseconds: cycle time, address access, write pulse, data setup, address setup, and the bus release delays after the write and output-enable strobes fall or rise. Each one is rounded up to whole clock cycles against the clock period parameter. A write is the overlap of select and write strobes both low. Select and write rise together to end it, so the bus is left floating. The controller's own data drivers switch on only once the memory has had time to release the bus, and are never on while the write strobe is high. After every read, a turnaround interval with output enable high keeps the next write from fighting the memory's drivers.

Top module: `sram_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `ms_n`, `we_n` and `oe_n` are 1 and `dq_oe` and `done` are 0.
- R2: A read (`req_wr`=0) brings `ms_n` and `oe_n` low on the clock edge that accepts it and holds them low for ceil(T_AA_NS/CLK_NS) cycles (4 by default), with `we_n` at 1 throughout.
- R3: Read data is sampled from `dq_in` on the edge that ends the access count, the same edge that returns `ms_n` and `oe_n` to 1. It then stays on `rd_data` until the next read completes.
- R4: `mem_addr` takes the request address on the accepting edge, together with the fall of `ms_n`, and stays unchanged while `ms_n` is low. For a write, `ms_n` is low for at least one whole cycle before `we_n` falls.
- R5: `dq_oe` is 1 only while `ms_n` and `we_n` are both low, and only after `we_n` has been low for ceil(T_HZWE_NS/CLK_NS) cycles (2 by default). It is never 1 while the memory is driving the bus (`ms_n`=0, `oe_n`=0, `we_n`=1).
- R6: `we_n` stays low for at least ceil(T_PWE_NS/CLK_NS) cycles (3 by default). Data is driven for at least ceil(T_SD_NS/CLK_NS) cycles (2 by default) before the write ends. `ms_n` and `we_n` rise on the same edge, so the written byte is stored at the address held during the access.
- R7: `oe_n` stays 1 for the whole of a write. After a read, `ms_n` and `oe_n` stay high for at least ceil(T_HZOE_NS/CLK_NS) cycles (2 by default) before `done`.
- R8: `done` is a one-cycle pulse on the cycle after the access returns to idle. A request is accepted only in the idle state, including the `done` cycle. Requests raised during a busy access have no effect on the strobes and no effect on memory.
- R9: Each nanosecond timing is rounded up to whole cycles, and each wait is at least one cycle. With defaults, a write occupies 1+2+2+1 cycles and a read 4+2 cycles before `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request, sampled only when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Byte to write |
| rd_data | output | DATA_W | Last byte read |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W | Address to the memory |
| ms_n | output | 1 | Memory select, active low |
| we_n | output | 1 | Write strobe, active low |
| oe_n | output | 1 | Output enable, active low |
| dq_out | output | DATA_W | Write data toward the memory |
| dq_oe | output | 1 | Enable for the controller's data drivers |
| dq_in | input | DATA_W | Data returned by the memory |

## Verification
Every strobe changes on the edge that accepts a request. With defaults, a write's `done` pulse is due 6 cycles after that edge and a read's is also due 6 cycles after it. The read byte lands on `rd_data` 4 edges after acceptance. When the bench issues a request, it pushes the expected per-cycle strobe, driver and completion values into a queue. It pops and compares one entry on each falling clock edge, half a cycle after the outputs settle, and checks `rd_data` in the pop that carries `done`. A behavioural memory commits bytes from the pins on the strobe overlap. Its contents are compared against an independent record of what the host asked for.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WSET  = 3'd1,
    ST_WHIZ  = 3'd2,
    ST_WDATA = 3'd3,
    ST_WREC  = 3'd4,
    ST_RACC  = 3'd5,
    ST_RREC  = 3'd6
  } seq_state_t;

  // whole cycles covering a nanosecond interval
  function automatic int cyc_up(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int at_least(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int L_SA   = 1,
  parameter int L_HZ   = 2,
  parameter int L_WD   = 2,
  parameter int L_WREC = 1,
  parameter int L_AA   = 4,
  parameter int L_RREC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             req_wr,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             ms_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe,
  output logic             done
);

  seq_state_t state, nxt;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state)
      ST_IDLE: if (req) begin
        tmr_load = 1'b1;
        if (req_wr) begin
          nxt     = ST_WSET;
          tmr_val = CNT_W'(L_SA - 1);
        end else begin
          nxt     = ST_RACC;
          tmr_val = CNT_W'(L_AA - 1);
        end
      end
      ST_WSET: if (tmr_zero) begin
        nxt = ST_WHIZ; tmr_load = 1'b1; tmr_val = CNT_W'(L_HZ - 1);
      end
      ST_WHIZ: if (tmr_zero) begin
        nxt = ST_WDATA; tmr_load = 1'b1; tmr_val = CNT_W'(L_WD - 1);
      end
      ST_WDATA: if (tmr_zero) begin
        nxt = ST_WREC; tmr_load = 1'b1; tmr_val = CNT_W'(L_WREC - 1);
      end
      ST_RACC: if (tmr_zero) begin
        nxt = ST_RREC; tmr_load = 1'b1; tmr_val = CNT_W'(L_RREC - 1);
      end
      ST_WREC, ST_RREC: if (tmr_zero) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  assign accept  = (state == ST_IDLE) && req;
  assign capture = (state == ST_RACC) && tmr_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      ms_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      ms_n  <= !(nxt inside {ST_WSET, ST_WHIZ, ST_WDATA, ST_RACC});
      we_n  <= !(nxt inside {ST_WHIZ, ST_WDATA});
      oe_n  <= !(nxt == ST_RACC);
      dq_oe <= (nxt == ST_WDATA);
      done  <= (state inside {ST_WREC, ST_RREC}) && (nxt == ST_IDLE);
    end
  end

endmodule

// File: rtl/sram_seq_dpath.sv
module sram_seq_dpath #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      dq_out   <= '0;
      rd_data  <= '0;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        dq_out   <= req_wdata;
      end
      if (capture)
        rd_data <= dq_in;
    end
  end

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 20,
  parameter int T_RC_NS   = 70,
  parameter int T_WC_NS   = 70,
  parameter int T_AA_NS   = 70,
  parameter int T_SA_NS   = 0,
  parameter int T_HZWE_NS = 30,
  parameter int T_SD_NS   = 30,
  parameter int T_PWE_NS  = 55,
  parameter int T_HZOE_NS = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              ms_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in
);

  localparam int C_SA   = at_least(1, cyc_up(T_SA_NS, CLK_NS));
  localparam int C_HZ   = at_least(1, cyc_up(T_HZWE_NS, CLK_NS));
  localparam int C_SD   = at_least(1, cyc_up(T_SD_NS, CLK_NS));
  localparam int C_PWE  = at_least(1, cyc_up(T_PWE_NS, CLK_NS));
  localparam int C_WD   = at_least(C_SD, C_PWE - C_HZ);
  localparam int C_WREC = at_least(1, cyc_up(T_WC_NS, CLK_NS) - C_SA - C_HZ - C_WD);
  localparam int C_AA   = at_least(1, cyc_up(T_AA_NS, CLK_NS));
  localparam int C_TA   = at_least(1, cyc_up(T_HZOE_NS, CLK_NS));
  localparam int C_RREC = at_least(C_TA, cyc_up(T_RC_NS, CLK_NS) - C_AA);
  localparam int C_MAX  = at_least(at_least(at_least(C_SA, C_HZ), at_least(C_WD, C_WREC)),
                                   at_least(C_AA, C_RREC));
  localparam int CNT_W  = $clog2(C_MAX + 1);
  localparam int PWE_CYC = C_HZ + C_WD;

  logic             tmr_load, tmr_zero, accept, capture;
  logic [CNT_W-1:0] tmr_val;

  sram_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sram_seq_ctrl #(
    .CNT_W (CNT_W),
    .L_SA  (C_SA),
    .L_HZ  (C_HZ),
    .L_WD  (C_WD),
    .L_WREC(C_WREC),
    .L_AA  (C_AA),
    .L_RREC(C_RREC)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .req_wr   (req_wr),
    .tmr_zero (tmr_zero),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .accept   (accept),
    .capture  (capture),
    .ms_n     (ms_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .dq_oe    (dq_oe),
    .done     (done)
  );

  sram_seq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .capture  (capture),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .dq_in    (dq_in),
    .mem_addr (mem_addr),
    .dq_out   (dq_out),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
  parameter int ADDR_W  = 21,
  parameter int PWE_CYC = 3,
  parameter int HZ_CYC  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              ms_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              dq_oe,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr
);

  int unsigned we_lo;

  always_ff @(posedge clk) begin
    if (rst || we_n) we_lo <= 0;
    else             we_lo <= we_lo + 1;
  end

  // R5
  drive_only_in_write_chk: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (!we_n && !ms_n && oe_n));

  // R5
  drive_after_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> (we_lo >= HZ_CYC));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4
  select_before_write_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(we_n) |-> (!ms_n && !$past(ms_n)));

  // R4
  addr_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (!ms_n && !$past(ms_n)) |-> $stable(mem_addr));

  // R6
  joint_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> $rose(ms_n));

  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> ($past(we_lo) + 1 >= PWE_CYC));

  // R7
  no_oe_in_write_chk: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> oe_n);

endmodule

bind sram_seq sram_seq_chk #(
  .ADDR_W (ADDR_W),
  .PWE_CYC(PWE_CYC),
  .HZ_CYC (C_HZ)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ms_n    (ms_n),
  .we_n    (we_n),
  .oe_n    (oe_n),
  .dq_oe   (dq_oe),
  .done    (done),
  .mem_addr(mem_addr)
);

// File: tb/sram_seq_bench.sv
`timescale 1ns/1ps
module sram_seq_bench;

  localparam int AW = 21;
  localparam int DW = 8;
  localparam int PER = 20;
  // expected wait lengths, rounded up from the nanosecond figures
  localparam int E_SA  = 1;
  localparam int E_HZ  = (30 + PER - 1) / PER;
  localparam int E_WD  = (30 + PER - 1) / PER;
  localparam int E_WR  = 1;
  localparam int E_AA  = (70 + PER - 1) / PER;
  localparam int E_RR  = (30 + PER - 1) / PER;
  localparam logic [DW-1:0] BLANK = 8'hA5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] rd_data, dq_out, dq_in;
  logic [AW-1:0] mem_addr;
  logic done, ms_n, we_n, oe_n, dq_oe;

  always #(PER/2) clk = ~clk;

  sram_seq u_sram_seq (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_data(rd_data), .done(done), .mem_addr(mem_addr),
    .ms_n(ms_n), .we_n(we_n), .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe),
    .dq_in(dq_in)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // {check read, ms_n, we_n, oe_n, dq_oe, done}
  logic [5:0]    exp_q[$];
  logic [DW-1:0] rd_q[$];
  logic [DW-1:0] ref_mem[logic [AW-1:0]];
  logic [DW-1:0] pin_mem[logic [AW-1:0]];
  logic [AW-1:0] cur_addr = '0;
  logic          pend = 1'b0;
  logic [DW-1:0] pdata;
  logic [AW-1:0] paddr;
  logic [DW-1:0] mem_dout = '0;

  assign dq_in = mem_dout;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic push_n(input logic [5:0] v, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(v);
  endtask

  function automatic logic [DW-1:0] look(input logic [AW-1:0] a);
    if (ref_mem.exists(a)) return ref_mem[a];
    return BLANK;
  endfunction

  // compare every cycle at the falling edge
  always @(negedge clk) begin
    logic [5:0] e;
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (!rst) begin
      e = (exp_q.size() != 0) ? exp_q.pop_front() : 6'b0_111_0_0;
      // R2 R4 R6 R7 R8 R9: full strobe trace
      chk("R2 R6 R7 R9 strobes {ms,we,oe}", {29'd0, ms_n, we_n, oe_n}, {29'd0, e[4:2]});
      chk("R5 driver enable", {31'd0, dq_oe}, {31'd0, e[1]});
      chk("R8 done pulse", {31'd0, done}, {31'd0, e[0]});
      if (!ms_n) chk("R4 address held", {11'd0, mem_addr}, {11'd0, cur_addr});
      if (dq_oe && !ms_n && !oe_n && we_n) chk("R5 bus contention", 32'd1, 32'd0);
      if (e[5]) chk("R3 read data", {24'd0, rd_data}, {24'd0, rd_q.pop_front()});
      // memory model: commit on the end of the strobe overlap
      if (!ms_n && !we_n && dq_oe) begin
        pend = 1'b1; pdata = dq_out; paddr = mem_addr;
      end else if (pend && (ms_n || we_n)) begin
        pin_mem[paddr] = pdata; pend = 1'b0;
      end
      if (!ms_n && !oe_n && we_n)
        mem_dout = pin_mem.exists(mem_addr) ? pin_mem[mem_addr] : BLANK;
      else
        mem_dout = 8'h00;
    end
  end

  task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    do begin
      @(negedge clk); #1;
    end while (exp_q.size() != 0);
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    cur_addr = a;
    if (wr) begin
      ref_mem[a] = d;
      push_n(6'b0_011_0_0, E_SA);
      push_n(6'b0_001_0_0, E_HZ);
      push_n(6'b0_001_1_0, E_WD);
      push_n(6'b0_111_0_0, E_WR);
      push_n(6'b0_111_0_1, 1);
    end else begin
      rd_q.push_back(look(a));
      push_n(6'b0_010_0_0, E_AA);
      push_n(6'b0_111_0_0, E_RR);
      push_n(6'b1_111_0_1, 1);
    end
    @(negedge clk); #1;
    req = 1'b0;
  endtask

  task automatic settle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1 reset strobes", {29'd0, ms_n, we_n, oe_n}, 32'd7);
    chk("R1 reset drivers/done", {30'd0, dq_oe, done}, 32'd0);
    #1 rst = 1'b0;

    // R9 R6: basic write then read back (R3)
    issue(1'b1, 21'h000123, 8'h5A);
    issue(1'b0, 21'h000123, 8'h00);
    settle();
    // patterns and high addresses, back to back (accepted on done cycle)
    issue(1'b1, 21'h1FFFFF, 8'hFF);
    issue(1'b1, 21'h100000, 8'h00);
    issue(1'b1, 21'h0AAAAA, 8'hAA);
    issue(1'b0, 21'h1FFFFF, 8'h00);
    issue(1'b0, 21'h100000, 8'h00);
    issue(1'b0, 21'h0AAAAA, 8'h00);
    // R7: read followed at once by a write, then read of unwritten location
    issue(1'b0, 21'h055555, 8'h00);
    issue(1'b1, 21'h055555, 8'h3C);
    issue(1'b0, 21'h055555, 8'h00);
    issue(1'b0, 21'h012345, 8'h00);
    settle();

    // R8: requests during a busy access are ignored
    issue(1'b1, 21'h001000, 8'hC3);
    req = 1'b1; req_wr = 1'b1; req_addr = 21'h002000; req_wdata = 8'hEE;
    repeat (3) @(negedge clk);
    #1 req = 1'b0;
    settle();
    issue(1'b0, 21'h002000, 8'h00);
    issue(1'b0, 21'h001000, 8'h00);
    settle();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule